// File: doc/BRIEF.md
# Two-Pattern Scan Delay-Test Sequencer

This block applies two-pattern delay tests through a multiplexed scan chain. On a start request it runs a burst of `NUM_PAT` tests. Each test first shifts an initial vector into the chain with scan enable high. It then runs a launch cycle and a capture cycle. After the capture, the captured response is shifted out while the next initial vector is shifted in. After the last capture, one extra unload pass drains the final response, and then a done pulse is issued.

Two launch styles are supported, and the style is chosen per burst. In shift-launch mode, scan enable stays high through the launch cycle, so the second vector is the first vector moved by one chain position. Scan enable falls only for the capture. In capture-launch mode, scan enable falls once loading ends. A programmable number of settling cycles may follow, during which the chain holds. Launch and capture are then two back-to-back functional clocks. The scan chain and a small combinational next-state function that stands in for the logic under test are modelled inside the block.

Top module: `scan_pair_seq`

## Requirements
- R1: After reset scan_en_o is 1, launch_o, capture_o and done_o are 0, and the chain is all zero, so scan_out_o is 0.
- R2: start_i is taken only while the block is idle. The mode (mode_i, 1 = shift-launch, 0 = capture-launch) and idle_cnt_i are latched at that moment. Later changes of start_i, mode_i or idle_cnt_i have no effect on the running burst.
- R3: Every load/unload pass lasts exactly CHAIN_LEN cycles with scan_en_o high. In each of these cycles chain bit 0 takes scan_in_i, bit i takes bit i-1, and scan_out_o always shows bit CHAIN_LEN-1. The response therefore leaves with its highest bit first.
- R4: In shift-launch mode the launch cycle (launch_o high) directly follows the load pass, keeps scan_en_o high and performs one more shift.
- R5: In capture-launch mode scan_en_o is low for exactly idle_cnt_i settling cycles after the load pass, and the chain holds during them. Then comes the launch cycle, with scan_en_o low, which applies the next-state function.
- R6: In shift-launch mode the latched idle count is ignored, and no settling cycles occur.
- R7: The capture cycle (capture_o high) is the cycle right after launch. In it scan_en_o is low and the chain takes f(x), where f(x)[i] = x[(i-1) mod N] XOR (x[i] AND x[(i+1) mod N]).
- R8: In the cycle after capture, scan_en_o is high again and an unload pass starts. One start runs NUM_PAT tests, followed by one final unload pass.
- R9: done_o is a one-cycle pulse in the cycle after the last unload shift. The block is idle in that cycle (scan_en_o high, chain holding) and accepts a new start in it.
- R10: launch_o and capture_o are never high together, and each is high exactly once per test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst of tests (taken only when idle) |
| mode_i | input | 1 | 1 = launch by shift, 0 = launch by functional clock |
| idle_cnt_i | input | IDLE_W | Settling cycles before launch in capture-launch mode |
| scan_in_i | input | 1 | Serial pattern bit |
| scan_out_o | output | 1 | Serial response bit (last chain stage) |
| scan_en_o | output | 1 | Scan enable to the chain |
| launch_o | output | 1 | High during the launch cycle |
| capture_o | output | 1 | High during the capture cycle |
| done_o | output | 1 | One-cycle pulse after the final unload |

## Verification
In every unload cycle, the outgoing response bit and the incoming bit of the next pattern move through the same chain shift. The bench drives fresh random scan-in bits throughout every unload pass and compares each scan_out_o bit against its own chain model. A corrupted response or a misaligned load therefore shows up in that cycle or in a later capture. The second collision is a done pulse meeting a new start. Several bursts are chained by asserting start_i in the done cycle, and the bench expects the next load pass to begin on the following cycle with the newly latched mode and idle count.

// File: rtl/scan_pair_seq_pkg.sv
package scan_pair_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_WAIT,
    ST_LAUNCH,
    ST_CAPT
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_SHIFT,
    OP_FUNC
  } chain_op_e;
endpackage

// File: rtl/cut_next.sv
module cut_next #(
  parameter int N = 8
) (
  input  logic [N-1:0] state_i,
  output logic [N-1:0] next_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign next_o[i] = state_i[(i + N - 1) % N] ^ (state_i[i] & state_i[(i + 1) % N]);
  end
endmodule

// File: rtl/scan_chain_model.sv
module scan_chain_model
  import scan_pair_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chain_op_e op_i,
  input  logic      si_i,
  output logic      so_o
);
  logic [N-1:0] chain_q;
  logic [N-1:0] func_d;

  cut_next #(.N(N)) u_cut (
    .state_i(chain_q),
    .next_o (func_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      case (op_i)
        OP_SHIFT: chain_q <= {chain_q[N-2:0], si_i};
        OP_FUNC:  chain_q <= func_d;
        default:  chain_q <= chain_q;
      endcase
    end
  end

  assign so_o = chain_q[N-1];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import scan_pair_seq_pkg::*;
#(
  parameter int N       = 8,
  parameter int NUM_PAT = 3,
  parameter int IDLE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              los_i,
  input  logic [IDLE_W-1:0] idle_i,
  output seq_state_e        state_o,
  output logic              los_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(N + 1);
  localparam int PAT_W = $clog2(NUM_PAT + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  sh_cnt_q;
  logic [PAT_W-1:0]  pat_cnt_q;
  logic [IDLE_W-1:0] wait_cnt_q, idle_q;
  logic              los_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_cnt_q   <= '0;
      pat_cnt_q  <= '0;
      wait_cnt_q <= '0;
      idle_q     <= '0;
      los_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_SHIFT;
            sh_cnt_q  <= '0;
            pat_cnt_q <= '0;
            los_q     <= los_i;
            idle_q    <= idle_i;
          end
        end
        ST_SHIFT: begin
          if (sh_cnt_q == CNT_W'(N - 1)) begin
            sh_cnt_q <= '0;
            if (pat_cnt_q == PAT_W'(NUM_PAT)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (los_q || idle_q == '0) begin
              state_q <= ST_LAUNCH;
            end else begin
              state_q    <= ST_WAIT;
              wait_cnt_q <= '0;
            end
          end else begin
            sh_cnt_q <= sh_cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (wait_cnt_q + 1'b1 == idle_q) state_q <= ST_LAUNCH;
          else wait_cnt_q <= wait_cnt_q + 1'b1;
        end
        ST_LAUNCH: state_q <= ST_CAPT;
        ST_CAPT: begin
          state_q   <= ST_SHIFT;
          pat_cnt_q <= pat_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign los_o   = los_q;
  assign done_o  = done_q;
endmodule

// File: rtl/scan_pair_seq.sv
module scan_pair_seq
  import scan_pair_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_PAT   = 3,
  parameter int IDLE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [IDLE_W-1:0] idle_cnt_i,
  input  logic              scan_in_i,
  output logic              scan_out_o,
  output logic              scan_en_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic              done_o
);
  seq_state_e state;
  chain_op_e  op;
  logic       los_q;

  seq_ctrl #(.N(CHAIN_LEN), .NUM_PAT(NUM_PAT), .IDLE_W(IDLE_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .los_i  (mode_i),
    .idle_i (idle_cnt_i),
    .state_o(state),
    .los_o  (los_q),
    .done_o (done_o)
  );

  always_comb begin
    case (state)
      ST_SHIFT:  op = OP_SHIFT;
      ST_LAUNCH: op = los_q ? OP_SHIFT : OP_FUNC;
      ST_CAPT:   op = OP_FUNC;
      default:   op = OP_HOLD;
    endcase
  end

  scan_chain_model #(.N(CHAIN_LEN)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .si_i  (scan_in_i),
    .so_o  (scan_out_o)
  );

  assign scan_en_o = (state == ST_IDLE) || (state == ST_SHIFT) || (state == ST_LAUNCH && los_q);
  assign launch_o  = (state == ST_LAUNCH);
  assign capture_o = (state == ST_CAPT);
endmodule

// File: rtl/scan_pair_seq_chk.sv
module scan_pair_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scan_en_o,
  input logic launch_o,
  input logic capture_o,
  input logic done_o,
  input logic los_q
);
  p_capt_follows_launch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> capture_o);
  p_capt_se_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> !scan_en_o);
  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && capture_o));
  p_single_launch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  p_los_launch_se_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && los_q) |-> scan_en_o);
  p_loc_launch_se_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && !los_q) |-> !scan_en_o);
  p_se_back_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> scan_en_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scan_en_o && !launch_o && !capture_o));
endmodule

bind scan_pair_seq scan_pair_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scan_en_o(scan_en_o),
  .launch_o (launch_o),
  .capture_o(capture_o),
  .done_o   (done_o),
  .los_q    (los_q)
);

// File: tb/scan_pair_seq_test.sv
module scan_pair_seq_test;
  localparam int N       = 8;
  localparam int NUM_PAT = 3;
  localparam int IDLE_W  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0, scan_in_i = 1'b0;
  logic [IDLE_W-1:0] idle_cnt_i = '0;
  logic scan_out_o, scan_en_o, launch_o, capture_o, done_o;

  int checks = 0, fails = 0;
  logic [N-1:0] m = '0;
  bit noise = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scan_pair_seq #(.CHAIN_LEN(N), .NUM_PAT(NUM_PAT), .IDLE_W(IDLE_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .idle_cnt_i(idle_cnt_i), .scan_in_i(scan_in_i), .scan_out_o(scan_out_o),
    .scan_en_o(scan_en_o), .launch_o(launch_o), .capture_o(capture_o), .done_o(done_o)
  );

  function automatic logic [N-1:0] f_next(input logic [N-1:0] x);
    logic [N-1:0] y;
    for (int i = 0; i < N; i++) y[i] = x[(i + N - 1) % N] ^ (x[i] & x[(i + 1) % N]);
    return y;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // kind: 0 hold, 1 shift, 2 next-state
  task automatic cyc(input bit se, input bit l, input bit c, input int kind, input string req);
    bit b;
    @(negedge clk);
    b = 1'($urandom);
    chk(req, scan_en_o, se);
    chk(req, launch_o, l);
    chk(req, capture_o, c);
    chk("R9 no early done", done_o, 0);
    chk({req, " scan_out"}, scan_out_o, m[N-1]);
    scan_in_i = b;
    if (noise) begin
      start_i    = 1'($urandom);
      mode_i     = 1'($urandom);
      idle_cnt_i = IDLE_W'($urandom);
    end else start_i = 1'b0;
    @(posedge clk);
    if (kind == 1) m = {m[N-2:0], b};
    else if (kind == 2) m = f_next(m);
  endtask

  // Runs one burst; optionally asserts the next start in the done cycle.
  task automatic run_burst(input bit los, input int idle, input bit skip_start,
                           input bit b2b, input bit nlos, input int nidle, input bit nz);
    if (!skip_start) begin
      @(negedge clk);
      chk("R9 idle se high", scan_en_o, 1);
      chk("R9 done low when idle", done_o, 0);
      start_i = 1'b1; mode_i = los; idle_cnt_i = IDLE_W'(idle);
      @(posedge clk);
    end
    noise = nz;
    for (int p = 0; p <= NUM_PAT; p++) begin
      for (int j = 0; j < N; j++) cyc(1, 0, 0, 1, "R3 shift pass");
      if (p == NUM_PAT) break;
      if (los) begin
        cyc(1, 1, 0, 1, "R4 R6 shift launch");
      end else begin
        for (int k = 0; k < idle; k++) cyc(0, 0, 0, 0, "R5 settle hold");
        cyc(0, 1, 0, 2, "R5 func launch");
      end
      cyc(0, 0, 1, 2, "R7 capture");
    end
    noise = 0;
    @(negedge clk);
    chk("R9 done pulse", done_o, 1);
    chk("R9 se high at done", scan_en_o, 1);
    chk("R10 no launch at done", launch_o, 0);
    chk("R9 chain holds", scan_out_o, m[N-1]);
    if (b2b) begin
      start_i = 1'b1; mode_i = nlos; idle_cnt_i = IDLE_W'(nidle);
    end else begin
      start_i = 1'b0; mode_i = ~nlos; idle_cnt_i = '1;
    end
    @(posedge clk);
    if (!b2b) begin
      @(negedge clk);
      chk("R9 done single cycle", done_o, 0);
      chk("R2 idle stays idle", scan_en_o, 1);
      chk("R2 no launch", launch_o, 0);
      chk("R2 chain idle", scan_out_o, m[N-1]);
    end
  endtask

  initial begin
    @(negedge clk);
    chk("R1 se at reset", scan_en_o, 1);
    chk("R1 launch at reset", launch_o, 0);
    chk("R1 capture at reset", capture_o, 0);
    chk("R1 done at reset", done_o, 0);
    chk("R1 scan_out at reset", scan_out_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R4 R6: shift-launch ignores nonzero idle counts
    run_burst(1, 0, 0, 0, 0, 0, 0);
    run_burst(1, 7, 0, 0, 0, 0, 0);
    // R5: capture-launch, sweep of idle counts
    for (int k = 0; k < 6; k++) run_burst(0, k, 0, 0, 0, 0, 0);
    run_burst(0, 15, 0, 0, 0, 0, 0);
    // R2: mid-burst start / mode / idle changes ignored
    run_burst(0, 2, 0, 0, 0, 0, 1);
    run_burst(1, 3, 0, 0, 0, 0, 1);
    // R9: start in done cycle, chained bursts with mode switches
    run_burst(1, 4, 0, 1, 0, 3, 0);
    run_burst(0, 3, 1, 1, 1, 9, 1);
    run_burst(1, 9, 1, 1, 0, 1, 0);
    run_burst(0, 1, 1, 0, 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule